// File: doc/BRIEF.md
# Daisy-Chain Sensor Bus Slave Protocol Engine

This block is the digital protocol engine of a sensor slave that sits on a two-wire, daisy-chained sensor bus. A front end outside the block turns bus activity into decoded frames. Each frame is presented for one clock cycle, with a length flag (short or long word), a 4-bit command, a 4-bit device address, 8 data bits and a 4-bit CRC. The engine checks the CRC, the command and the address, and then executes the command. It assigns its own address during initialization and drives the switch that powers the next slave down the chain. It also holds a small format register file and the self-test enable, and it reaches the sensor sample, a register bank and a nonvolatile store through plain ports.

A reply is never sent in the frame that asked for it. The reply is held and goes out once, when the next frame is taken. After every frame the engine ignores the bus for a fixed window, which is a short one normally and a long one after an initialization that closes the downstream switch. A `busy` flag shows when either window is running.

Top module: `sbus_slave`

## Requirements
- R1: The engine supports codes 0 (init), 1 (status), 2 (sample read), 4 (identity), 7 (clear), 9 (nonvolatile access), 10 (format), 11 (register read), 12 (self-test off), 13 (self-test on) and 15 (reverse init). Codes 3, 5, 6, 8 and 14 are executed as nothing and queue no reply.
- R2: The frame CRC is x^4+x+1 with seed 4'hA, computed MSB first over the 16 bits {data, address, command}. A frame whose CRC field does not match is not executed and queues no reply.
- R3: A short frame has its data treated as zero, both for the CRC and for execution. Codes 0, 9, 10, 11 and 15 are ignored when they arrive in a short frame.
- R4: A frame is executed only when its address equals the device address, which is 0 after reset. Init and reverse init set the device address to data[3:0] and set `busSwitch` to data[6] (1 = closed).
- R5: When a frame is taken and a reply is pending, `respValid` pulses for one cycle after that clock edge, and the pending reply is then dropped, so it is sent exactly once. `respWord` is {payload[7:0], address[3:0], command[3:0], crc[3:0]}, with the crc computed as in R2 over the upper 16 bits. The address is the device address after execution.
- R6: Every frame taken raises `busy` for SHORT_WIN cycles. Frames that arrive while `busy` is high are not executed, emit no reply and leave the pending reply in place.
- R7: An executed init or reverse init with data[6]=1 raises `busy` for LONG_WIN cycles instead.
- R8: The payloads are as follows. Status gives {busSwitch, selfTest, 2'b00, device address}. Sample read gives `accelIn`. Identity gives DEVICE_ID. Register read gives `regRdData`, with `regAddr` = data[3:0]. Init and reverse init echo the data.
- R9: Format control writes data[3:0] into format entry data[6:4]. Its payload is {0, entry, previous content of the entry}.
- R10: Nonvolatile access drives `nvmAddr` = data[6:4] and `nvmWrData` = data[3:0]. It asserts `nvmWrEn` during the frame cycle only when data[7]=1, and its payload is {0, data[6:4], nvmRdData}.
- R11: Self-test on sets `selfTest` and returns payload 1. Self-test off clears it and returns payload 0. Clear zeroes `selfTest` and all format entries and returns payload 0.
- R12: After reset, `busy`, `respValid`, `busSwitch` and `selfTest` are low and no reply is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameValid | input | 1 | One-cycle strobe for a decoded frame |
| frameLong | input | 1 | 1 = long word frame, 0 = short word frame |
| frameCmd | input | 4 | Command code |
| frameAddr | input | 4 | Target device address |
| frameData | input | 8 | Frame data (used only for long frames) |
| frameCrc | input | 4 | CRC received with the frame |
| accelIn | input | 8 | Current sensor sample |
| regAddr | output | 4 | Register bank address |
| regRdData | input | 8 | Register bank read data |
| nvmAddr | output | 3 | Nonvolatile store address |
| nvmWrEn | output | 1 | Nonvolatile write enable |
| nvmWrData | output | 4 | Nonvolatile write data |
| nvmRdData | input | 4 | Nonvolatile read data |
| respValid | output | 1 | Reply strobe |
| respWord | output | 20 | Reply word with CRC |
| busy | output | 1 | Bus-ignore window running |
| busSwitch | output | 1 | Downstream bus switch, 1 = closed |
| selfTest | output | 1 | Self-test stimulus enable |

## Verification
Each command is sent as a well-formed frame and then followed by a probe frame that carries an unimplemented code. The reply seen at the probe therefore belongs to the command alone, and the absence of a reply can be separated from a late one. The same status request is sent in several variants: with the right address, with a stale address, with a corrupted CRC, and as a short frame with junk data. Together these separate the address, CRC and length rules. Frames sent inside the ignore window, repeated probes, and both init variants with the switch open and closed show the exactly-once delivery and the two window lengths.

// File: rtl/sbus_slave_pkg.sv
package sbus_slave_pkg;

  localparam logic [3:0] CMD_INIT   = 4'd0;
  localparam logic [3:0] CMD_STATUS = 4'd1;
  localparam logic [3:0] CMD_ACCEL  = 4'd2;
  localparam logic [3:0] CMD_ID     = 4'd4;
  localparam logic [3:0] CMD_CLEAR  = 4'd7;
  localparam logic [3:0] CMD_NVM    = 4'd9;
  localparam logic [3:0] CMD_FORMAT = 4'd10;
  localparam logic [3:0] CMD_REGRD  = 4'd11;
  localparam logic [3:0] CMD_STOFF  = 4'd12;
  localparam logic [3:0] CMD_STON   = 4'd13;
  localparam logic [3:0] CMD_RINIT  = 4'd15;

  localparam logic [3:0] CRC_SEED = 4'hA;
  localparam logic [3:0] CRC_POLY = 4'h3;

  // Strobes from control to datapath, valid in the frame cycle
  typedef struct packed {
    logic take;     // frame accepted (bus not ignored)
    logic exec;     // frame accepted, checked and addressed here
    logic doInit;
    logic doFmt;
    logic doNvmWr;
    logic stOn;
    logic stOff;
    logic doClear;
  } ctrl_t;

  function automatic logic [3:0] crc4(input logic [15:0] msg);
    logic [3:0] c;
    logic fb;
    c = CRC_SEED;
    for (int i = 15; i >= 0; i--) begin
      fb = c[3] ^ msg[i];
      c  = {c[2:0], 1'b0} ^ ({4{fb}} & CRC_POLY);
    end
    return c;
  endfunction

endpackage

// File: rtl/sbus_slave_ctrl.sv
module sbus_slave_ctrl
  import sbus_slave_pkg::*;
#(
  parameter int SHORT_WIN = 18,
  parameter int LONG_WIN  = 180
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameValid,
  input  logic       frameLong,
  input  logic [3:0] frameCmd,
  input  logic [3:0] frameAddr,
  input  logic [7:0] frameData,
  input  logic [3:0] frameCrc,
  input  logic [3:0] myAddr,
  output logic [7:0] effData,
  output ctrl_t      strb,
  output logic       busy
);
  localparam int CW = $clog2(LONG_WIN + 1);

  logic [CW-1:0] winCnt;
  logic crcOk, supported, needsLong, isInit, addrHit, take, exec;

  assign effData = frameLong ? frameData : 8'h00;
  assign crcOk   = (crc4({effData, frameAddr, frameCmd}) == frameCrc);
  assign isInit  = (frameCmd == CMD_INIT) || (frameCmd == CMD_RINIT);
  assign addrHit = (frameAddr == myAddr);

  always_comb begin
    supported = 1'b1;
    needsLong = 1'b0;
    case (frameCmd)
      CMD_INIT, CMD_RINIT, CMD_NVM, CMD_FORMAT, CMD_REGRD: needsLong = 1'b1;
      CMD_STATUS, CMD_ACCEL, CMD_ID, CMD_CLEAR, CMD_STOFF, CMD_STON: ;
      default: supported = 1'b0;
    endcase
  end

  assign take = frameValid && !busy;
  assign exec = take && crcOk && supported && (frameLong || !needsLong) && addrHit;

  always_comb begin
    strb         = '0;
    strb.take    = take;
    strb.exec    = exec;
    strb.doInit  = exec && isInit;
    strb.doFmt   = exec && (frameCmd == CMD_FORMAT);
    strb.doNvmWr = exec && (frameCmd == CMD_NVM) && effData[7];
    strb.stOn    = exec && (frameCmd == CMD_STON);
    strb.stOff   = exec && (frameCmd == CMD_STOFF);
    strb.doClear = exec && (frameCmd == CMD_CLEAR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      winCnt <= '0;
    else if (take)
      winCnt <= (exec && isInit && effData[6]) ? CW'(LONG_WIN) : CW'(SHORT_WIN);
    else if (winCnt != '0)
      winCnt <= winCnt - 1'b1;
  end

  assign busy = (winCnt != '0);

endmodule

// File: rtl/sbus_slave_dp.sv
module sbus_slave_dp
  import sbus_slave_pkg::*;
#(
  parameter logic [7:0] DEVICE_ID = 8'h5A,
  parameter int         FMT_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrl_t       strb,
  input  logic [3:0]  frameCmd,
  input  logic [7:0]  effData,
  input  logic [7:0]  accelIn,
  input  logic [7:0]  regRdData,
  input  logic [3:0]  nvmRdData,
  output logic [3:0]  myAddr,
  output logic        busSwitch,
  output logic        selfTest,
  output logic        respValid,
  output logic [19:0] respWord
);
  localparam int FA_W = $clog2(FMT_DEPTH);

  logic [3:0]      fmtReg [FMT_DEPTH];
  logic [FA_W-1:0] fmtIdx;
  logic [7:0]      payload;
  logic [3:0]      newAddr;
  logic [19:0]     newWord, pendWord;
  logic            pendValid;

  assign fmtIdx  = effData[4 +: FA_W];
  assign newAddr = strb.doInit ? effData[3:0] : myAddr;

  always_comb begin
    case (frameCmd)
      CMD_INIT, CMD_RINIT: payload = effData;
      CMD_STATUS:          payload = {busSwitch, selfTest, 2'b00, myAddr};
      CMD_ACCEL:           payload = accelIn;
      CMD_ID:              payload = DEVICE_ID;
      CMD_NVM:             payload = {1'b0, effData[6:4], nvmRdData};
      CMD_FORMAT:          payload = {1'b0, effData[6:4], fmtReg[fmtIdx]};
      CMD_REGRD:           payload = regRdData;
      CMD_STON:            payload = 8'h01;
      default:             payload = 8'h00;
    endcase
  end

  assign newWord = {payload, newAddr, frameCmd, crc4({payload, newAddr, frameCmd})};

  for (genvar i = 0; i < FMT_DEPTH; i++) begin : g_fmt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        fmtReg[i] <= '0;
      else if (strb.doClear)
        fmtReg[i] <= '0;
      else if (strb.doFmt && fmtIdx == FA_W'(i))
        fmtReg[i] <= effData[3:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      myAddr    <= '0;
      busSwitch <= 1'b0;
      selfTest  <= 1'b0;
    end else begin
      if (strb.doInit) begin
        myAddr    <= effData[3:0];
        busSwitch <= effData[6];
      end
      if (strb.stOn)
        selfTest <= 1'b1;
      else if (strb.stOff || strb.doClear)
        selfTest <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendWord  <= '0;
      respValid <= 1'b0;
      respWord  <= '0;
    end else if (strb.take) begin
      respValid <= pendValid;
      respWord  <= pendWord;
      pendValid <= strb.exec;
      if (strb.exec)
        pendWord <= newWord;
    end else begin
      respValid <= 1'b0;
    end
  end

endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
  import sbus_slave_pkg::*;
#(
  parameter int         SHORT_WIN = 18,
  parameter int         LONG_WIN  = 180,
  parameter logic [7:0] DEVICE_ID = 8'h5A,
  parameter int         FMT_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameValid,
  input  logic        frameLong,
  input  logic [3:0]  frameCmd,
  input  logic [3:0]  frameAddr,
  input  logic [7:0]  frameData,
  input  logic [3:0]  frameCrc,
  input  logic [7:0]  accelIn,
  output logic [3:0]  regAddr,
  input  logic [7:0]  regRdData,
  output logic [2:0]  nvmAddr,
  output logic        nvmWrEn,
  output logic [3:0]  nvmWrData,
  input  logic [3:0]  nvmRdData,
  output logic        respValid,
  output logic [19:0] respWord,
  output logic        busy,
  output logic        busSwitch,
  output logic        selfTest
);
  ctrl_t      strb;
  logic [7:0] effData;
  logic [3:0] myAddr;

  sbus_slave_ctrl #(.SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameLong(frameLong),
    .frameCmd(frameCmd), .frameAddr(frameAddr), .frameData(frameData),
    .frameCrc(frameCrc), .myAddr(myAddr), .effData(effData), .strb(strb),
    .busy(busy)
  );

  sbus_slave_dp #(.DEVICE_ID(DEVICE_ID), .FMT_DEPTH(FMT_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .frameCmd(frameCmd), .effData(effData),
    .accelIn(accelIn), .regRdData(regRdData), .nvmRdData(nvmRdData),
    .myAddr(myAddr), .busSwitch(busSwitch), .selfTest(selfTest),
    .respValid(respValid), .respWord(respWord)
  );

  assign regAddr   = effData[3:0];
  assign nvmAddr   = effData[6:4];
  assign nvmWrData = effData[3:0];
  assign nvmWrEn   = strb.doNvmWr;

endmodule

// File: rtl/sbus_slave_chk.sv
module sbus_slave_chk #(
  parameter int LONG_WIN = 180
) (
  input logic clk,
  input logic rstN,
  input logic frameValid,
  input logic frameLong,
  input logic busy,
  input logic respValid,
  input logic nvmWrEn,
  input logic busSwitch
);
  localparam int RW = $clog2(LONG_WIN + 2);
  logic [RW-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy && busyRun <= RW'(LONG_WIN)) busyRun <= busyRun + 1'b1;
    else if (!busy) busyRun <= '0;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RW'(LONG_WIN)); // R7
  AST_FRAME_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !busy) |=> busy); // R6
  AST_RESP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R5
  AST_RESP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> busy); // R5
  AST_NVM_WR_LONG_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    nvmWrEn |-> (frameValid && frameLong && !busy)); // R10
  AST_SWITCH_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> $stable(busSwitch)); // R4

endmodule

bind sbus_slave sbus_slave_chk #(.LONG_WIN(LONG_WIN)) chk_i (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameLong(frameLong),
  .busy(busy), .respValid(respValid), .nvmWrEn(nvmWrEn), .busSwitch(busSwitch)
);

// File: tb/sbus_slave_tb_top.sv
module sbus_slave_tb_top;
  localparam int SW = 18;
  localparam int LW = 180;

  logic clk = 1'b0, rstN = 1'b0;
  logic frameValid = 1'b0, frameLong = 1'b0;
  logic [3:0] frameCmd = '0, frameAddr = '0, frameCrc = '0;
  logic [7:0] frameData = '0, accelIn = 8'h3C;
  logic [3:0] regAddr, nvmWrData, nvmRdData;
  logic [7:0] regRdData;
  logic [2:0] nvmAddr;
  logic nvmWrEn, respValid, busy, busSwitch, selfTest;
  logic [19:0] respWord;

  int checks = 0, errors = 0, n;
  bit done = 0;
  logic gotResp, wrSeen;
  logic [19:0] gotWord;
  logic [2:0] wrA;
  logic [3:0] wrD;

  always #2 clk = ~clk;

  assign regRdData = {regAddr, ~regAddr};
  assign nvmRdData = {1'b0, nvmAddr} ^ 4'hF;

  sbus_slave #(.SHORT_WIN(SW), .LONG_WIN(LW)) dut_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameLong(frameLong),
    .frameCmd(frameCmd), .frameAddr(frameAddr), .frameData(frameData),
    .frameCrc(frameCrc), .accelIn(accelIn), .regAddr(regAddr),
    .regRdData(regRdData), .nvmAddr(nvmAddr), .nvmWrEn(nvmWrEn),
    .nvmWrData(nvmWrData), .nvmRdData(nvmRdData), .respValid(respValid),
    .respWord(respWord), .busy(busy), .busSwitch(busSwitch), .selfTest(selfTest)
  );

  function automatic logic [3:0] crcOf(input logic [15:0] m);
    logic [3:0] c = 4'hA;
    logic fb;
    for (int i = 15; i >= 0; i--) begin
      fb = c[3] ^ m[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic sendFrame(input logic lng, input logic [3:0] c, input logic [3:0] a,
                           input logic [7:0] d, input logic corrupt);
    @(negedge clk);
    frameValid = 1'b1; frameLong = lng; frameCmd = c; frameAddr = a; frameData = d;
    frameCrc = crcOf({lng ? d : 8'h00, a, c}) ^ (corrupt ? 4'h1 : 4'h0);
    #1;
    wrSeen = nvmWrEn; wrA = nvmAddr; wrD = nvmWrData;
    @(posedge clk);
    @(negedge clk);
    gotResp = respValid; gotWord = respWord;
    frameValid = 1'b0;
  endtask

  task automatic waitIdle(output int cnt);
    cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic probe(input string tag, input logic expResp, input logic [7:0] pay,
                       input logic [3:0] addr, input logic [3:0] cmd);
    int k;
    sendFrame(1'b1, 4'd3, 4'd0, 8'h00, 1'b0);
    check({tag, " respValid"}, 32'(gotResp), 32'(expResp));
    if (expResp)
      check({tag, " respWord"}, 32'(gotWord),
            32'({pay, addr, cmd, crcOf({pay, addr, cmd})}));
    waitIdle(k);
  endtask

  task automatic runCase(input string tag, input logic lng, input logic [3:0] c,
                         input logic [3:0] a, input logic [7:0] d, input logic bad,
                         input logic expResp, input logic [7:0] pay, input logic [3:0] ra);
    int k;
    sendFrame(lng, c, a, d, bad);
    waitIdle(k);
    probe(tag, expResp, pay, ra, c);
  endtask

  task automatic testReset();
    check("R12 busy", 32'(busy), 0);
    check("R12 respValid", 32'(respValid), 0);
    check("R12 busSwitch", 32'(busSwitch), 0);
    check("R12 selfTest", 32'(selfTest), 0);
    probe("R12 nothing pending", 1'b0, 8'h00, 4'd0, 4'd3);
  endtask

  task automatic testInit();
    runCase("R8 status at addr 0", 1'b1, 4'd1, 4'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd0);
    sendFrame(1'b1, 4'd0, 4'd0, 8'h35, 1'b0);
    waitIdle(n);
    check("R6 short window", n, SW);
    check("R4 switch open", 32'(busSwitch), 0);
    probe("R4 init reply", 1'b1, 8'h35, 4'd5, 4'd0);
    runCase("R4 old address ignored", 1'b1, 4'd1, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd0);
  endtask

  task automatic testRejects();
    runCase("R2 bad crc", 1'b1, 4'd1, 4'd5, 8'h00, 1'b1, 1'b0, 8'h00, 4'd5);
    runCase("R1 code 6", 1'b1, 4'd6, 4'd5, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5);
    runCase("R1 code 14", 1'b1, 4'd14, 4'd5, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5);
    runCase("R3 short regread", 1'b0, 4'd11, 4'd5, 8'h07, 1'b0, 1'b0, 8'h00, 4'd5);
    runCase("R3 short status junk data", 1'b0, 4'd1, 4'd5, 8'hFF, 1'b0, 1'b1, 8'h05, 4'd5);
  endtask

  task automatic testReads();
    runCase("R8 sample", 1'b0, 4'd2, 4'd5, 8'h00, 1'b0, 1'b1, 8'h3C, 4'd5);
    runCase("R8 identity", 1'b1, 4'd4, 4'd5, 8'h00, 1'b0, 1'b1, 8'h5A, 4'd5);
    runCase("R8 regread", 1'b1, 4'd11, 4'd5, 8'h07, 1'b0, 1'b1, 8'h78, 4'd5);
  endtask

  task automatic testFormatSelfTest();
    runCase("R9 format first", 1'b1, 4'd10, 4'd5, 8'h39, 1'b0, 1'b1, 8'h30, 4'd5);
    runCase("R9 format readback", 1'b1, 4'd10, 4'd5, 8'h31, 1'b0, 1'b1, 8'h39, 4'd5);
    runCase("R11 self-test on", 1'b1, 4'd13, 4'd5, 8'h00, 1'b0, 1'b1, 8'h01, 4'd5);
    check("R11 selfTest high", 32'(selfTest), 1);
    runCase("R8 status flags", 1'b0, 4'd1, 4'd5, 8'h00, 1'b0, 1'b1, 8'h45, 4'd5);
    runCase("R11 clear", 1'b1, 4'd7, 4'd5, 8'h00, 1'b0, 1'b1, 8'h00, 4'd5);
    check("R11 selfTest cleared", 32'(selfTest), 0);
    runCase("R11 format cleared", 1'b1, 4'd10, 4'd5, 8'h30, 1'b0, 1'b1, 8'h30, 4'd5);
    runCase("R11 self-test off", 1'b1, 4'd12, 4'd5, 8'h00, 1'b0, 1'b1, 8'h00, 4'd5);
  endtask

  task automatic testNvm();
    sendFrame(1'b1, 4'd9, 4'd5, 8'hAB, 1'b0);
    check("R10 write enable", 32'(wrSeen), 1);
    check("R10 write addr", 32'(wrA), 2);
    check("R10 write data", 32'(wrD), 32'hB);
    waitIdle(n);
    probe("R10 nvm reply", 1'b1, 8'h2D, 4'd5, 4'd9);
    sendFrame(1'b1, 4'd9, 4'd5, 8'h2B, 1'b0);
    check("R10 read no write", 32'(wrSeen), 0);
    waitIdle(n);
    probe("R10 nvm read reply", 1'b1, 8'h2D, 4'd5, 4'd9);
  endtask

  task automatic testWindow();
    sendFrame(1'b1, 4'd1, 4'd5, 8'h00, 1'b0);
    sendFrame(1'b1, 4'd4, 4'd5, 8'h00, 1'b0);
    check("R6 no reply while busy", 32'(gotResp), 0);
    waitIdle(n);
    probe("R6 first frame kept", 1'b1, 8'h05, 4'd5, 4'd1);
    probe("R5 sent exactly once", 1'b0, 8'h00, 4'd5, 4'd1);
  endtask

  task automatic testLongInit();
    sendFrame(1'b1, 4'd0, 4'd5, 8'h49, 1'b0);
    waitIdle(n);
    check("R7 long window", n, LW);
    check("R7 switch closed", 32'(busSwitch), 1);
    probe("R7 init reply", 1'b1, 8'h49, 4'd9, 4'd0);
    sendFrame(1'b1, 4'd15, 4'd9, 8'h09, 1'b0);
    waitIdle(n);
    check("R4 reverse init short window", n, SW);
    check("R4 switch reopened", 32'(busSwitch), 0);
    probe("R4 reverse init reply", 1'b1, 8'h09, 4'd9, 4'd15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInit();
    testRejects();
    testReads();
    testFormatSelfTest();
    testNvm();
    testWindow();
    testLongInit();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule